// File: doc/BRIEF.md
# Tag-Renaming Out-of-Order Issue Core

This block is a compact dynamic scheduler for integer arithmetic. Instructions arrive one at a time, in program order, on a valid/ready issue port. Each instruction names an operation (add, subtract, multiply or divide), a destination register and two source registers in an eight-entry register file. On acceptance the instruction is parked in a reservation station of its operation class. Every station has its own tag. A per-register status table records which tag will produce each register's next value. This renaming lets later instructions run out of order around earlier, slower ones.

Finished stations compete for one shared result bus. The bus carries at most one result per cycle and the oldest finished instruction wins. A broadcast does three things: it wakes every station waiting on that tag, it updates the register only when that register still names the tag, and it appears on the completion outputs. A debug port reads register contents combinationally. Back-pressure is plain: `iss_ready` is low when every station of the presented operation's class is occupied. An instruction is taken only in a cycle where both `iss_valid` and `iss_ready` are high. `iss_ready` depends only on the presented opcode and internal state.

Top module: `ooo_sched_core`

## Requirements
- R1: After reset, register n holds the value n, no completion is reported, and the issue port is ready for every operation.
- R2: Instructions are accepted in program order, at most one per cycle, on cycles where iss_valid and iss_ready are both high. The opcode encoding is 0 add, 1 subtract, 2 multiply, 3 divide.
- R3: An instruction whose sources are ready at issue in cycle t broadcasts in cycle t+1+L, where L is 2 for add/subtract, 6 for multiply and 12 for divide, unless it loses bus arbitration.
- R4: At most one result is broadcast per cycle. Among finished stations the one issued earliest wins, and the others keep their results and retry in later cycles.
- R5: A station waiting on a tag captures the operand at that tag's broadcast and begins execution in the following cycle.
- R6: A source that is ready at issue is copied into the station at once, so a later write to that register does not change the instruction's result.
- R7: When two in-flight instructions write the same register, the register ends holding the result of the one issued later, whichever finishes first.
- R8: Issue stalls (iss_ready low) when all four stations of the presented operation's class are occupied, while other classes stay ready. A station becomes free the cycle after its broadcast.
- R9: Add and subtract wrap modulo 2^16. Multiply returns the low 16 bits of the product. Divide returns the unsigned quotient, and division by zero returns all ones.
- R10: An instruction issued in the same cycle that its source's producer broadcasts takes that value from the bus and begins execution in the next cycle.
- R11: Each broadcast raises cmp_valid for one cycle with the destination register and result value, and no completion is reported while no station is occupied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request present |
| iss_ready | output | 1 | A station of the presented class is free |
| iss_op | input | 2 | Operation: 0 add, 1 sub, 2 mul, 3 div |
| iss_dst | input | 3 | Destination register index |
| iss_src_a | input | 3 | First source register index |
| iss_src_b | input | 3 | Second source register index |
| cmp_valid | output | 1 | Result broadcast this cycle |
| cmp_tag | output | 4 | Tag of the broadcasting station |
| cmp_dst | output | 3 | Destination register of the broadcast |
| cmp_value | output | 16 | Broadcast result value |
| dbg_addr | input | 3 | Register index for debug read |
| dbg_data | output | 16 | Contents of register dbg_addr |

## Verification
The assertions assume that reset is asserted before the first activity and that the issue inputs carry known values whenever iss_valid is high. They do not depend on how long the requester holds an offer. Every opcode is legal, so no stimulus filtering is needed. Each directed scenario starts from a fresh reset and presents instructions only at falling edges. A scenario waits until the pipeline drains before reading registers, so the occupancy accounting the checker relies on always starts from an empty machine.

// File: rtl/ooo_pkg.sv
package ooo_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MUL = 2'd2,
    OP_DIV = 2'd3
  } op_e;

  localparam int NCLS = 3;

  // class 0: add/sub, class 1: multiply, class 2: divide
  function automatic logic [1:0] op_class(op_e op);
    case (op)
      OP_MUL:  return 2'd1;
      OP_DIV:  return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/ooo_exec_unit.sv
module ooo_exec_unit import ooo_pkg::*; #(
  parameter int DW   = 16,
  parameter int KIND = 0
) (
  input  op_e           op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] res_o
);

  generate
    if (KIND == 0) begin : g_addsub
      always_comb res_o = (op_i == OP_SUB) ? (a_i - b_i) : (a_i + b_i);
    end else if (KIND == 1) begin : g_mul
      always_comb res_o = (op_i == OP_MUL) ? (a_i * b_i) : '0;
    end else begin : g_div
      always_comb begin
        if (op_i != OP_DIV)   res_o = '0;
        else if (b_i == '0)   res_o = '1;
        else                  res_o = a_i / b_i;
      end
    end
  endgenerate

endmodule

// File: rtl/ooo_rs_bank.sv
module ooo_rs_bank import ooo_pkg::*; #(
  parameter  int DW   = 16,
  parameter  int RPC  = 4,
  parameter  int TW   = 4,
  parameter  int SEQW = 6,
  parameter  int RW   = 3,
  parameter  int LAT  = 2,
  parameter  int KIND = 0,
  localparam int IW   = (RPC > 1) ? $clog2(RPC) : 1,
  localparam int CNTW = $clog2(LAT + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       alloc_i,
  input  op_e                        alloc_op_i,
  input  logic [RW-1:0]              alloc_dst_i,
  input  logic [SEQW-1:0]            alloc_seq_i,
  input  logic                       a_rdy_i,
  input  logic [TW-1:0]              a_tag_i,
  input  logic [DW-1:0]              a_val_i,
  input  logic                       b_rdy_i,
  input  logic [TW-1:0]              b_tag_i,
  input  logic [DW-1:0]              b_val_i,
  input  logic                       bus_valid_i,
  input  logic [TW-1:0]              bus_tag_i,
  input  logic [DW-1:0]              bus_val_i,
  input  logic [RPC-1:0]             grant_i,
  output logic                       free_o,
  output logic [IW-1:0]              free_idx_o,
  output logic [RPC-1:0]             busy_o,
  output logic [RPC-1:0]             req_o,
  output logic [RPC-1:0][SEQW-1:0]   seq_o,
  output logic [DW-1:0]              res_o,
  output logic [RW-1:0]              res_dst_o
);

  logic [RPC-1:0]            busy_q, pa_q, pb_q;
  logic [RPC-1:0][TW-1:0]    ta_q, tb_q;
  logic [RPC-1:0][DW-1:0]    va_q, vb_q;
  logic [RPC-1:0][RW-1:0]    dst_q;
  logic [RPC-1:0][SEQW-1:0]  seq_q;
  logic [RPC-1:0][CNTW-1:0]  cnt_q;
  op_e                       op_q [RPC];

  // lowest-numbered free station takes the next allocation
  always_comb begin
    free_o     = 1'b0;
    free_idx_o = '0;
    for (int i = RPC - 1; i >= 0; i--) begin
      if (!busy_q[i]) begin
        free_o     = 1'b1;
        free_idx_o = IW'(i);
      end
    end
  end

  generate
    for (genvar i = 0; i < RPC; i++) begin : g_st
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          busy_q[i] <= 1'b0;
          pa_q[i]   <= 1'b0;
          pb_q[i]   <= 1'b0;
          ta_q[i]   <= '0;
          tb_q[i]   <= '0;
          va_q[i]   <= '0;
          vb_q[i]   <= '0;
          dst_q[i]  <= '0;
          seq_q[i]  <= '0;
          cnt_q[i]  <= '0;
          op_q[i]   <= OP_ADD;
        end else if (alloc_i && (free_idx_o == IW'(i))) begin
          busy_q[i] <= 1'b1;
          op_q[i]   <= alloc_op_i;
          dst_q[i]  <= alloc_dst_i;
          seq_q[i]  <= alloc_seq_i;
          pa_q[i]   <= !a_rdy_i;
          ta_q[i]   <= a_tag_i;
          va_q[i]   <= a_val_i;
          pb_q[i]   <= !b_rdy_i;
          tb_q[i]   <= b_tag_i;
          vb_q[i]   <= b_val_i;
          cnt_q[i]  <= '0;
        end else if (busy_q[i]) begin
          if (grant_i[i]) begin
            busy_q[i] <= 1'b0;
          end else begin
            if (pa_q[i] && bus_valid_i && (bus_tag_i == ta_q[i])) begin
              pa_q[i] <= 1'b0;
              va_q[i] <= bus_val_i;
            end
            if (pb_q[i] && bus_valid_i && (bus_tag_i == tb_q[i])) begin
              pb_q[i] <= 1'b0;
              vb_q[i] <= bus_val_i;
            end
            // execution advances only once both operands are held
            if (!pa_q[i] && !pb_q[i] && (cnt_q[i] != CNTW'(LAT)))
              cnt_q[i] <= cnt_q[i] + 1'b1;
          end
        end
      end

      assign req_o[i] = busy_q[i] && (cnt_q[i] == CNTW'(LAT));
      assign seq_o[i] = seq_q[i];
    end
  endgenerate

  assign busy_o = busy_q;

  op_e            sel_op;
  logic [DW-1:0]  sel_a, sel_b, alu_res;
  logic [RW-1:0]  sel_dst;

  always_comb begin
    sel_op  = OP_ADD;
    sel_a   = '0;
    sel_b   = '0;
    sel_dst = '0;
    for (int i = 0; i < RPC; i++) begin
      if (grant_i[i]) begin
        sel_op  = op_q[i];
        sel_a   = va_q[i];
        sel_b   = vb_q[i];
        sel_dst = dst_q[i];
      end
    end
  end

  ooo_exec_unit #(.DW(DW), .KIND(KIND)) u_exec (
    .op_i  (sel_op),
    .a_i   (sel_a),
    .b_i   (sel_b),
    .res_o (alu_res)
  );

  assign res_o     = (|grant_i) ? alu_res : '0;
  assign res_dst_o = (|grant_i) ? sel_dst : '0;

endmodule

// File: rtl/ooo_cdb_arb.sv
module ooo_cdb_arb #(
  parameter int N  = 12,
  parameter int SW = 6
) (
  input  logic [N-1:0]          req_i,
  input  logic [N-1:0][SW-1:0]  seq_i,
  output logic [N-1:0]          grant_o
);

  // modular age compare: a issued before b when (a - b) is negative
  function automatic logic is_older(logic [SW-1:0] a, logic [SW-1:0] b);
    logic [SW-1:0] d;
    d = a - b;
    return d[SW-1];
  endfunction

  logic          found;
  int            best;
  logic [SW-1:0] best_seq;

  always_comb begin
    found    = 1'b0;
    best     = 0;
    best_seq = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && (!found || is_older(seq_i[i], best_seq))) begin
        found    = 1'b1;
        best     = i;
        best_seq = seq_i[i];
      end
    end
    grant_o = '0;
    if (found) grant_o[best] = 1'b1;
  end

endmodule

// File: rtl/ooo_sched_core.sv
module ooo_sched_core import ooo_pkg::*; #(
  parameter  int DW           = 16,
  parameter  int NREG         = 8,
  parameter  int RS_PER_CLASS = 4,
  parameter  int LAT_ADD      = 2,
  parameter  int LAT_MUL      = 6,
  parameter  int LAT_DIV      = 12,
  parameter  int SEQW         = 6,
  localparam int RW           = $clog2(NREG),
  localparam int NST          = NCLS * RS_PER_CLASS,
  localparam int TW           = $clog2(NST),
  localparam int IW           = (RS_PER_CLASS > 1) ? $clog2(RS_PER_CLASS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           iss_valid,
  output logic           iss_ready,
  input  logic [1:0]     iss_op,
  input  logic [RW-1:0]  iss_dst,
  input  logic [RW-1:0]  iss_src_a,
  input  logic [RW-1:0]  iss_src_b,
  output logic           cmp_valid,
  output logic [TW-1:0]  cmp_tag,
  output logic [RW-1:0]  cmp_dst,
  output logic [DW-1:0]  cmp_value,
  input  logic [RW-1:0]  dbg_addr,
  output logic [DW-1:0]  dbg_data
);

  // architectural state and rename table
  logic [NREG-1:0][DW-1:0] rf_q;
  logic [NREG-1:0]         pend_q;
  logic [NREG-1:0][TW-1:0] ptag_q;
  logic [SEQW-1:0]         seq_q;

  // per-class bank signals
  logic [NCLS-1:0]                          bk_free;
  logic [NCLS-1:0][IW-1:0]                  bk_idx;
  logic [NCLS-1:0][RS_PER_CLASS-1:0]        bk_busy, bk_req, bk_grant;
  logic [NCLS-1:0][RS_PER_CLASS-1:0][SEQW-1:0] bk_seq;
  logic [NCLS-1:0][DW-1:0]                  bk_res;
  logic [NCLS-1:0][RW-1:0]                  bk_dst;

  logic [NST-1:0]           all_busy, all_req, all_grant;
  logic [NST-1:0][SEQW-1:0] all_seq;

  assign all_busy  = bk_busy;
  assign all_req   = bk_req;
  assign all_seq   = bk_seq;
  assign bk_grant  = all_grant;

  // result bus
  logic           bus_valid;
  logic [TW-1:0]  bus_tag;
  logic [DW-1:0]  bus_val;
  logic [RW-1:0]  bus_dst;

  always_comb begin
    bus_tag = '0;
    for (int i = 0; i < NST; i++)
      if (all_grant[i]) bus_tag = TW'(i);
    bus_val = '0;
    bus_dst = '0;
    for (int c = 0; c < NCLS; c++) begin
      bus_val = bus_val | bk_res[c];
      bus_dst = bus_dst | bk_dst[c];
    end
  end
  assign bus_valid = |all_grant;

  // issue decode
  op_e        dec_op;
  logic [1:0] dec_cls;
  logic       iss_fire;
  logic [TW-1:0] new_tag;

  assign dec_op    = op_e'(iss_op);
  assign dec_cls   = op_class(dec_op);
  assign iss_ready = bk_free[dec_cls];
  assign iss_fire  = iss_valid && iss_ready;
  assign new_tag   = TW'(dec_cls) * TW'(RS_PER_CLASS) + TW'(bk_idx[dec_cls]);

  // source lookup with same-cycle bus bypass
  logic          a_rdy, b_rdy;
  logic [TW-1:0] a_tag, b_tag;
  logic [DW-1:0] a_val, b_val;

  always_comb begin
    a_tag = ptag_q[iss_src_a];
    if (!pend_q[iss_src_a]) begin
      a_rdy = 1'b1;
      a_val = rf_q[iss_src_a];
    end else if (bus_valid && (bus_tag == ptag_q[iss_src_a])) begin
      a_rdy = 1'b1;
      a_val = bus_val;
    end else begin
      a_rdy = 1'b0;
      a_val = '0;
    end
    b_tag = ptag_q[iss_src_b];
    if (!pend_q[iss_src_b]) begin
      b_rdy = 1'b1;
      b_val = rf_q[iss_src_b];
    end else if (bus_valid && (bus_tag == ptag_q[iss_src_b])) begin
      b_rdy = 1'b1;
      b_val = bus_val;
    end else begin
      b_rdy = 1'b0;
      b_val = '0;
    end
  end

  generate
    for (genvar c = 0; c < NCLS; c++) begin : g_bank
      localparam int LAT_C = (c == 0) ? LAT_ADD : ((c == 1) ? LAT_MUL : LAT_DIV);
      ooo_rs_bank #(
        .DW(DW), .RPC(RS_PER_CLASS), .TW(TW), .SEQW(SEQW),
        .RW(RW), .LAT(LAT_C), .KIND(c)
      ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_i     (iss_fire && (dec_cls == 2'(c))),
        .alloc_op_i  (dec_op),
        .alloc_dst_i (iss_dst),
        .alloc_seq_i (seq_q),
        .a_rdy_i     (a_rdy),
        .a_tag_i     (a_tag),
        .a_val_i     (a_val),
        .b_rdy_i     (b_rdy),
        .b_tag_i     (b_tag),
        .b_val_i     (b_val),
        .bus_valid_i (bus_valid),
        .bus_tag_i   (bus_tag),
        .bus_val_i   (bus_val),
        .grant_i     (bk_grant[c]),
        .free_o      (bk_free[c]),
        .free_idx_o  (bk_idx[c]),
        .busy_o      (bk_busy[c]),
        .req_o       (bk_req[c]),
        .seq_o       (bk_seq[c]),
        .res_o       (bk_res[c]),
        .res_dst_o   (bk_dst[c])
      );
    end
  endgenerate

  ooo_cdb_arb #(.N(NST), .SW(SEQW)) u_arb (
    .req_i   (all_req),
    .seq_i   (all_seq),
    .grant_o (all_grant)
  );

  // register file and status table
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) begin
        rf_q[r]   <= DW'(r);
        pend_q[r] <= 1'b0;
        ptag_q[r] <= '0;
      end
      seq_q <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (bus_valid && pend_q[r] && (ptag_q[r] == bus_tag)) begin
          rf_q[r]   <= bus_val;
          pend_q[r] <= 1'b0;
        end
        if (iss_fire && (iss_dst == RW'(r))) begin
          pend_q[r] <= 1'b1;
          ptag_q[r] <= new_tag;
        end
      end
      if (iss_fire) seq_q <= seq_q + 1'b1;
    end
  end

  assign cmp_valid = bus_valid;
  assign cmp_tag   = bus_tag;
  assign cmp_dst   = bus_dst;
  assign cmp_value = bus_val;
  assign dbg_data  = rf_q[dbg_addr];

endmodule

// File: rtl/ooo_sched_core_chk.sv
module ooo_sched_core_chk #(
  parameter int NST = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic           iss_fire,
  input logic [NST-1:0] st_busy,
  input logic [NST-1:0] st_req,
  input logic [NST-1:0] st_grant,
  input logic           cmp_valid
);

  // R4: the arbiter never hands the bus to two stations at once
  assert_grant_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(st_grant));

  // R4: only a finished station may be granted
  assert_grant_needs_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_grant & ~st_req) == '0);

  // R4: a finished station that loses keeps its result and keeps asking
  assert_loser_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(st_req & ~st_grant)) |=> (($past(st_req & ~st_grant) & ~st_req) == '0));

  // R2: occupancy moves by one per accepted issue and one per broadcast
  assert_occupancy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ($countones(st_busy) ==
               $countones($past(st_busy)) + int'($past(iss_fire)) - int'($past(cmp_valid))));

  // R11: an empty machine reports no completion
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_busy == '0) |-> !cmp_valid);

endmodule

bind ooo_sched_core ooo_sched_core_chk #(.NST(3 * RS_PER_CLASS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .iss_fire  (iss_fire),
  .st_busy   (all_busy),
  .st_req    (all_req),
  .st_grant  (all_grant),
  .cmp_valid (cmp_valid)
);

// File: tb/ooo_sched_core_tb.sv
module ooo_sched_core_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iss_valid = 1'b0;
  logic        iss_ready;
  logic [1:0]  iss_op = 2'd0;
  logic [2:0]  iss_dst = 3'd0, iss_src_a = 3'd0, iss_src_b = 3'd0;
  logic        cmp_valid;
  logic [3:0]  cmp_tag;
  logic [2:0]  cmp_dst;
  logic [15:0] cmp_value;
  logic [2:0]  dbg_addr = 3'd0;
  logic [15:0] dbg_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  int ev_n = 0;
  int ev_dst [64];
  int ev_val [64];
  int ev_cyc [64];

  localparam logic [1:0] ADD = 2'd0, SUB = 2'd1, MUL = 2'd2, DIV = 2'd3;

  ooo_sched_core u_dut (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_op(iss_op),
    .iss_dst(iss_dst), .iss_src_a(iss_src_a), .iss_src_b(iss_src_b),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_dst(cmp_dst), .cmp_value(cmp_value),
    .dbg_addr(dbg_addr), .dbg_data(dbg_data)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // completion log, sampled mid-cycle
  always @(negedge clk) begin
    if (!rst_n) ev_n = 0;
    else if (cmp_valid && ev_n < 64) begin
      ev_dst[ev_n] = int'(cmp_dst);
      ev_val[ev_n] = int'(cmp_value);
      ev_cyc[ev_n] = cyc;
      ev_n = ev_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    iss_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic issue(input logic [1:0] op, input int d, input int a, input int b, output int acc);
    iss_valid = 1'b1;
    iss_op    = op;
    iss_dst   = 3'(d);
    iss_src_a = 3'(a);
    iss_src_b = 3'(b);
    forever begin
      #1;
      if (iss_ready) break;
      @(negedge clk);
    end
    acc = cyc;
    @(negedge clk);
    iss_valid = 1'b0;
  endtask

  task automatic read_reg(input int r, output int v);
    dbg_addr = 3'(r);
    #1;
    v = int'(dbg_data);
  endtask

  task automatic expect_ev(input int k, input int d, input int v, input int c, input string req);
    chk(ev_n > k, req, "event present", ev_n, k + 1);
    if (ev_n > k) begin
      chk(ev_dst[k] == d, req, "completion dst", ev_dst[k], d);
      chk(ev_val[k] == v, req, "completion value", ev_val[k], v);
      chk(ev_cyc[k] == c, req, "completion cycle", ev_cyc[k], c);
    end
  endtask

  task automatic expect_reg(input int r, input int v, input string req);
    int got;
    read_reg(r, got);
    chk(got == v, req, $sformatf("register %0d", r), got, v);
  endtask

  // R1 reset state
  task automatic t_reset();
    do_reset();
    for (int r = 0; r < 8; r++) expect_reg(r, r, "R1");
    for (int o = 0; o < 4; o++) begin
      iss_op = 2'(o);
      #1;
      chk(iss_ready == 1'b1, "R1", "ready after reset", int'(iss_ready), 1);
    end
    idle(2);
    chk(ev_n == 0, "R1", "no completion after reset", ev_n, 0);
  endtask

  // R3 R9 R11 latencies and arithmetic, one instruction at a time
  task automatic t_latency();
    int c;
    do_reset();
    issue(ADD, 1, 2, 3, c); idle(16);
    expect_ev(0, 1, 5, c + 3, "R3");
    issue(SUB, 4, 2, 3, c); idle(16);
    expect_ev(1, 4, 16'hFFFF, c + 3, "R9");
    issue(MUL, 5, 6, 7, c); idle(16);
    expect_ev(2, 5, 42, c + 7, "R3");
    issue(DIV, 6, 7, 2, c); idle(16);
    expect_ev(3, 6, 3, c + 13, "R3");
    issue(DIV, 3, 7, 0, c); idle(16);
    expect_ev(4, 3, 16'hFFFF, c + 13, "R9");
    issue(MUL, 7, 4, 4, c); idle(16);
    expect_ev(5, 7, 1, c + 7, "R9");
    expect_reg(6, 3, "R11");
    expect_reg(7, 1, "R11");
  endtask

  // R5 R6 R2 classic dependent chain with a write-after-read
  task automatic t_chain();
    int c1, c2, c3, c4;
    do_reset();
    issue(MUL, 0, 2, 4, c1);
    issue(ADD, 6, 0, 7, c2);
    issue(SUB, 7, 5, 3, c3);
    issue(DIV, 5, 6, 0, c4);
    chk(c2 == c1 + 1 && c3 == c1 + 2 && c4 == c1 + 3, "R2", "back-to-back issue", c4 - c1, 3);
    idle(30);
    expect_ev(0, 7, 2, c1 + 5, "R3");
    expect_ev(1, 0, 8, c1 + 7, "R3");
    expect_ev(2, 6, 15, c1 + 10, "R5");
    expect_ev(3, 5, 1, c1 + 23, "R5");
    expect_reg(6, 15, "R6");
    expect_reg(7, 2, "R6");
  endtask

  // R4 simultaneous finishers, oldest first, loser held
  task automatic t_collide();
    int c, d, e;
    do_reset();
    issue(MUL, 1, 2, 3, c);
    idle(3);
    issue(ADD, 4, 5, 6, d);
    issue(ADD, 7, 0, 2, e);
    idle(16);
    expect_ev(0, 1, 6, c + 7, "R4");
    expect_ev(1, 4, 11, c + 8, "R4");
    expect_ev(2, 7, 2, c + 9, "R4");
  endtask

  // R7 two writers of one register; dependent reads youngest
  task automatic t_waw();
    int c, d, e;
    do_reset();
    issue(MUL, 1, 2, 3, c);
    issue(ADD, 1, 4, 5, d);
    issue(ADD, 2, 1, 0, e);
    idle(16);
    expect_ev(0, 1, 9, c + 4, "R7");
    expect_ev(1, 1, 6, c + 7, "R7");
    expect_ev(2, 2, 9, c + 8, "R5");
    expect_reg(1, 9, "R7");
    expect_reg(2, 9, "R7");
  endtask

  // R8 class-full stall
  task automatic t_stall();
    int c, x, acc;
    do_reset();
    issue(MUL, 1, 2, 2, c);
    issue(MUL, 3, 4, 4, x);
    issue(MUL, 5, 6, 6, x);
    issue(MUL, 7, 6, 7, x);
    iss_op = ADD;
    #1;
    chk(iss_ready == 1'b1, "R8", "other class ready", int'(iss_ready), 1);
    iss_op = MUL;
    #1;
    chk(iss_ready == 1'b0, "R8", "full class stalls", int'(iss_ready), 0);
    issue(MUL, 0, 4, 2, acc);
    chk(acc == c + 8, "R8", "stalled issue accepted", acc - c, 8);
    idle(16);
    expect_ev(0, 1, 4, c + 7, "R8");
    expect_ev(3, 7, 42, c + 10, "R8");
    expect_ev(4, 0, 8, c + 15, "R8");
  endtask

  // R10 issue in the producer's broadcast cycle
  task automatic t_bypass();
    int c, d;
    do_reset();
    issue(MUL, 1, 2, 3, c);
    idle(6);
    issue(ADD, 4, 1, 1, d);
    chk(d == c + 7, "R10", "issue lands on broadcast cycle", d - c, 7);
    idle(12);
    expect_ev(0, 1, 6, c + 7, "R10");
    expect_ev(1, 4, 12, c + 10, "R10");
  endtask

  initial begin
    t_reset();
    t_latency();
    t_chain();
    t_collide();
    t_waw();
    t_stall();
    t_bypass();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule